// File: doc/BRIEF.md
# SPI Packet Mailbox Slave

This block lets an external SPI master trade 32-byte packets with a local processor. The master frames every access the same way. First comes a command byte, then an address byte, then the data bytes. The clock idles low, both sides sample on the rising edge, and bits change on the falling edge. Within each byte the most significant bit goes first. The SPI pins are brought into the system clock domain through two-stage synchronisers, so the SPI clock must be several times slower than `clk`.

The block holds four pieces of state:
- a receive buffer that the master fills;
- a transmit buffer that the local side fills;
- a 32-bit status word that either side may write;
- five done flags.

Both buffers appear locally as eight 32-bit words. Two active-high notify lines tell the master about local activity. One rises when local logic writes the status word, and the other rises when a transmit packet is loaded. Each line drops once the master has completed the matching read. The local side enables the done flags one by one and clears them by writing ones. The `irq` output is the OR of the flags that are both set and enabled.

Transmit words enter through a valid/ready port. The `tx_ready` output is low while chip select is asserted, and a word offered then is held off until the frame ends. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The `tx_valid`, `tx_idx`, `tx_data` and `tx_last` inputs must stay steady until that edge. Receive words are read combinationally by index.

Top module: `spi_pkt_mailbox`

## Requirements
- R1: SPI mode 0 framing. Byte 1 is the command and byte 2 is the address. Data bytes follow, MSB first, and data byte k is the k-th byte after the address. Clocks after the 32nd data byte are ignored.
- R2: Command 0x02 with address 0x00 and all 32 data bytes, ended by chip select rising, replaces the receive buffer. Data byte k lands in word k/4 at bits [8*(k%4)+7 : 8*(k%4)], which is little-endian.
- R3: If chip select rises before a frame's required data bytes are complete, the buffers, the status word, the flags and the notify lines are all left unchanged.
- R4: A frame with an unknown command changes no buffer, status or flag. So does a 0x02 frame whose address is not 0x00.
- R5: Commands 0x04 and 0x05 return the status word on MISO. Status byte j comes from bits [8j+7:8j], and bytes after the fourth read as zero. The first bit of every data byte is valid before that byte's first rising clock edge. MISO is low outside a frame.
- R6: `sts_notify` goes high on the cycle after a local status write (`sts_wr_en`). It goes low after a completed status read (at least 4 data bytes). When both happen on the same cycle, setting wins.
- R7: Command 0x01 with at least 4 data bytes loads the status word from data bytes 0..3, in little-endian order, and leaves `sts_notify` unchanged.
- R8: An accepted transmit word with `tx_last` high raises `tx_notify`. Command 0x03 shifts out transmit bytes 0..31, packed like R2. A completed read of all 32 bytes lowers `tx_notify`.
- R9: `tx_ready` is low while chip select is low. An offered word is not written then, and a refused `tx_last` does not raise `tx_notify`.
- R10: Flag bit positions are:
  - bit 0: any recognised frame completed;
  - bit 1: status written by the master;
  - bit 2: status read;
  - bit 3: receive buffer written;
  - bit 4: transmit buffer read.
- R11: Writing a 1 to a bit of `flag_clr` clears that flag on the next cycle. A flag set on the same cycle stays set.
- R12: `irq` is high exactly when some bit of `flags & flag_en` is 1.
- R13: After reset:
  - `flags`, `irq`, `sts_notify`, `tx_notify`, `spi_miso` and `sts_q` are zero;
  - both buffers are zero;
  - `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from master, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data |
| sts_wr_en | input | 1 | Local status write strobe |
| sts_wr_data | input | 32 | Local status write value |
| sts_q | output | 32 | Current status word |
| rx_rd_idx | input | 3 | Receive word index |
| rx_rd_word | output | 32 | Receive word at `rx_rd_idx` |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be accepted |
| tx_idx | input | 3 | Transmit word index |
| tx_data | input | 32 | Transmit word value |
| tx_last | input | 1 | Marks the word that completes a packet |
| flag_en | input | 5 | Per-flag interrupt enables |
| flag_clr | input | 5 | Write-one-to-clear for flags |
| flags | output | 5 | Done flags |
| irq | output | 1 | OR of enabled, set flags |
| sts_notify | output | 1 | Status-changed line to master |
| tx_notify | output | 1 | Transmit-data-ready line to master |

## Verification
The hardest situations to reach from the ports are the ones where chip select and the local side interact. One is a frame cut short partway through the data phase. Another is a transmit word offered while a frame is open. The bench bit-bangs the master and can raise chip select after any bit count, which lets it abort a buffer write after 20 data bytes. It also holds chip select low with no clocks while it offers a `tx_last` word, and then reads the transmit buffer back to show that the word was refused. Random packets and status values come from a fixed-seed `$urandom`. Expected words are packed by a bench function.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STS_BYTES = 4;
  localparam int FLAG_N    = 5;

  localparam int FL_XFER = 0;
  localparam int FL_STSW = 1;
  localparam int FL_STSR = 2;
  localparam int FL_BUFW = 3;
  localparam int FL_BUFR = 4;

  typedef enum logic [7:0] {
    OP_STS_WR  = 8'h01,
    OP_BUF_WR  = 8'h02,
    OP_BUF_RD  = 8'h03,
    OP_STS_RD0 = 8'h04,
    OP_STS_RD1 = 8'h05
  } op_e;

  typedef struct packed {
    logic sts_wr;
    logic sts_rd;
    logic buf_wr;
    logic buf_rd;
  } done_t;
endpackage

// File: rtl/mbx_spi_front.sv
module mbx_spi_front #(
  parameter int BUF_BYTES = 32,
  localparam int BW = $clog2(BUF_BYTES),
  localparam int NW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          active,
  output logic          frame_end,
  output logic [7:0]    cmd,
  output logic [7:0]    addr,
  output logic [NW-1:0] nbytes,
  output logic          byte_vld,
  output logic [BW-1:0] byte_idx,
  output logic [7:0]    byte_data,
  output logic [BW-1:0] out_idx,
  input  logic [7:0]    out_byte
);
  logic [1:0] sclk_sy, cs_sy, mosi_sy;
  logic       sclk_d, cs_d;
  logic       rise, fall, full;
  logic [2:0] bitpos;
  logic [1:0] phase;
  logic [6:0] sh;
  logic [7:0] nb;
  logic [NW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk};
      cs_sy   <= {cs_sy[0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
      sclk_d  <= sclk_sy[1];
      cs_d    <= cs_sy[1];
    end
  end

  assign active    = ~cs_sy[1];
  assign frame_end = cs_sy[1] & ~cs_d;
  assign rise      = active & sclk_sy[1] & ~sclk_d;
  assign fall      = active & ~sclk_sy[1] & sclk_d;
  assign full      = (phase == 2'd2) && (dcnt == NW'(BUF_BYTES));
  assign nb        = {sh, mosi_sy[1]};
  assign nbytes    = dcnt;
  assign out_idx   = dcnt[BW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos    <= '0;
      phase     <= '0;
      sh        <= '0;
      dcnt      <= '0;
      cmd       <= '0;
      addr      <= '0;
      byte_vld  <= 1'b0;
      byte_idx  <= '0;
      byte_data <= '0;
      miso      <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (!active) begin
        bitpos <= '0;
        phase  <= '0;
        dcnt   <= '0;
        cmd    <= '0;
        addr   <= '0;
        miso   <= 1'b0;
      end else begin
        if (rise && !full) begin
          sh     <= nb[6:0];
          bitpos <= bitpos + 3'd1;
          if (bitpos == 3'd7) begin
            unique case (phase)
              2'd0: begin cmd <= nb; phase <= 2'd1; end
              2'd1: begin addr <= nb; phase <= 2'd2; end
              default: begin
                byte_vld  <= 1'b1;
                byte_idx  <= dcnt[BW-1:0];
                byte_data <= nb;
                dcnt      <= dcnt + NW'(1);
              end
            endcase
          end
        end
        if (fall) begin
          if (phase == 2'd2 && dcnt < NW'(BUF_BYTES)) miso <= out_byte[3'd7 - bitpos];
          else miso <= 1'b0;
        end
      end
    end
  end

  property p_idle_clears;
    @(posedge clk) disable iff (!rst_n) !active |=> (dcnt == '0) && (bitpos == '0) && !miso;
  endproperty
  assert_idle_clears_R3: assert property (p_idle_clears);

  property p_dcnt_bound;
    @(posedge clk) disable iff (!rst_n) dcnt <= NW'(BUF_BYTES);
  endproperty
  assert_dcnt_bound_R1: assert property (p_dcnt_bound);
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int BUF_BYTES = 32,
  localparam int NWORDS = BUF_BYTES / 4,
  localparam int IW = $clog2(NWORDS),
  localparam int BW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_idx,
  input  logic [7:0]    byte_data,
  input  logic          commit_rx,
  output logic [31:0]   stage_w0,
  input  logic [IW-1:0] rx_idx,
  output logic [31:0]   rx_word,
  input  logic          busy,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [IW-1:0] tx_idx,
  input  logic [31:0]   tx_data,
  output logic          tx_take,
  input  logic [BW-1:0] out_idx,
  output logic [7:0]    out_byte
);
  logic [7:0] stage [BUF_BYTES];
  logic [31:0] stage_word [NWORDS];
  logic [NWORDS-1:0][31:0] rx_q, tx_q;
  logic [31:0] tw;

  for (genvar w = 0; w < NWORDS; w++) begin : g_pack
    assign stage_word[w] = {stage[4*w+3], stage[4*w+2], stage[4*w+1], stage[4*w]};
  end

  assign tx_ready = ~busy;
  assign tx_take  = tx_valid & tx_ready;
  assign stage_w0 = stage_word[0];
  assign rx_word  = rx_q[rx_idx];
  assign tw       = tx_q[out_idx[BW-1:2]];
  assign out_byte = tw[{out_idx[1:0], 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) stage[i] <= '0;
    end else if (byte_vld) begin
      stage[byte_idx] <= byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (commit_rx) begin
      for (int w = 0; w < NWORDS; w++) rx_q[w] <= stage_word[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (tx_take) tx_q[tx_idx] <= tx_data;
  end

  property p_rx_hold;
    @(posedge clk) disable iff (!rst_n) !commit_rx |=> $stable(rx_q);
  endproperty
  assert_rx_hold_R4: assert property (p_rx_hold);

  property p_tx_backpressure;
    @(posedge clk) disable iff (!rst_n) busy |=> $stable(tx_q);
  endproperty
  assert_tx_backpressure_R9: assert property (p_tx_backpressure);
endmodule

// File: rtl/mbx_notify.sv
module mbx_notify
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set,
  input  logic [FLAG_N-1:0] clr,
  input  logic [FLAG_N-1:0] en,
  input  logic              sts_set,
  input  logic              sts_clr,
  input  logic              tx_set,
  input  logic              tx_clr,
  output logic [FLAG_N-1:0] flags,
  output logic              irq,
  output logic              sts_notify,
  output logic              tx_notify
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      sts_notify <= 1'b0;
      tx_notify  <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | set;
      if (sts_set) sts_notify <= 1'b1;
      else if (sts_clr) sts_notify <= 1'b0;
      if (tx_set) tx_notify <= 1'b1;
      else if (tx_clr) tx_notify <= 1'b0;
    end
  end

  assign irq = |(flags & en);

  property p_clear;
    @(posedge clk) disable iff (!rst_n) 1'b1 |=> ((flags & $past(clr & ~set)) == '0);
  endproperty
  assert_w1c_clear_R11: assert property (p_clear);

  property p_sts_drop;
    @(posedge clk) disable iff (!rst_n) (sts_clr && !sts_set) |=> !sts_notify;
  endproperty
  assert_sts_drop_R6: assert property (p_sts_drop);

  property p_sts_rise;
    @(posedge clk) disable iff (!rst_n) sts_set |=> sts_notify;
  endproperty
  assert_sts_rise_R6: assert property (p_sts_rise);

  property p_tx_drop;
    @(posedge clk) disable iff (!rst_n) (tx_clr && !tx_set) |=> !tx_notify;
  endproperty
  assert_tx_drop_R8: assert property (p_tx_drop);
endmodule

// File: rtl/spi_pkt_mailbox.sv
module spi_pkt_mailbox
  import mbx_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  localparam int NWORDS = BUF_BYTES / 4,
  localparam int IW = $clog2(NWORDS),
  localparam int BW = $clog2(BUF_BYTES),
  localparam int NW = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              sts_wr_en,
  input  logic [31:0]       sts_wr_data,
  output logic [31:0]       sts_q,
  input  logic [IW-1:0]     rx_rd_idx,
  output logic [31:0]       rx_rd_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [IW-1:0]     tx_idx,
  input  logic [31:0]       tx_data,
  input  logic              tx_last,
  input  logic [FLAG_N-1:0] flag_en,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [FLAG_N-1:0] flags,
  output logic              irq,
  output logic              sts_notify,
  output logic              tx_notify
);
  logic          active, frame_end, byte_vld, tx_take;
  logic [7:0]    cmd, addr, byte_data, out_byte, buf_byte, sts_byte;
  logic [NW-1:0] nbytes;
  logic [BW-1:0] byte_idx, out_idx;
  logic [31:0]   stage_w0;
  logic          sts_cmd, have_sts, have_buf;
  done_t         done;
  logic [FLAG_N-1:0] fset;

  mbx_spi_front #(.BUF_BYTES(BUF_BYTES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso), .active(active), .frame_end(frame_end), .cmd(cmd), .addr(addr),
    .nbytes(nbytes), .byte_vld(byte_vld), .byte_idx(byte_idx), .byte_data(byte_data),
    .out_idx(out_idx), .out_byte(out_byte)
  );

  assign sts_cmd  = (cmd == OP_STS_RD0) || (cmd == OP_STS_RD1);
  assign have_sts = nbytes >= NW'(STS_BYTES);
  assign have_buf = nbytes == NW'(BUF_BYTES);

  assign done.sts_wr = frame_end && (cmd == OP_STS_WR) && have_sts;
  assign done.sts_rd = frame_end && sts_cmd && have_sts;
  assign done.buf_wr = frame_end && (cmd == OP_BUF_WR) && (addr == 8'h00) && have_buf;
  assign done.buf_rd = frame_end && (cmd == OP_BUF_RD) && have_buf;

  assign sts_byte = (out_idx < BW'(STS_BYTES)) ? sts_q[{out_idx[1:0], 3'b000} +: 8] : 8'h00;
  assign out_byte = sts_cmd ? sts_byte : buf_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else if (sts_wr_en) sts_q <= sts_wr_data;
    else if (done.sts_wr) sts_q <= stage_w0;
  end

  mbx_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
    .byte_data(byte_data), .commit_rx(done.buf_wr), .stage_w0(stage_w0),
    .rx_idx(rx_rd_idx), .rx_word(rx_rd_word), .busy(active),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx), .tx_data(tx_data),
    .tx_take(tx_take), .out_idx(out_idx), .out_byte(buf_byte)
  );

  always_comb begin
    fset          = '0;
    fset[FL_XFER] = done.sts_wr | done.sts_rd | done.buf_wr | done.buf_rd;
    fset[FL_STSW] = done.sts_wr;
    fset[FL_STSR] = done.sts_rd;
    fset[FL_BUFW] = done.buf_wr;
    fset[FL_BUFR] = done.buf_rd;
  end

  mbx_notify u_notify (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .en(flag_en),
    .sts_set(sts_wr_en), .sts_clr(done.sts_rd),
    .tx_set(tx_take & tx_last), .tx_clr(done.buf_rd),
    .flags(flags), .irq(irq), .sts_notify(sts_notify), .tx_notify(tx_notify)
  );

  property p_master_sts_quiet;
    @(posedge clk) disable iff (!rst_n) (done.sts_wr && !sts_wr_en) |=> $stable(sts_notify);
  endproperty
  assert_master_sts_quiet_R7: assert property (p_master_sts_quiet);
endmodule

// File: tb/spi_pkt_mailbox_test.sv
module spi_pkt_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
  logic sts_wr_en = 1'b0;
  logic [31:0] sts_wr_data = '0, sts_q, rx_rd_word, tx_data = '0;
  logic [2:0] rx_rd_idx = '0, tx_idx = '0;
  logic tx_valid = 1'b0, tx_ready, tx_last = 1'b0;
  logic [4:0] flag_en = '0, flag_clr = '0, flags;
  logic irq, sts_notify, tx_notify;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mo [32];
  logic [7:0] mi [32];
  logic [31:0] exp_rx [8];
  logic [31:0] exp_tx [8];
  logic [31:0] seed_sink;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pkt_mailbox uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sts_wr_en(sts_wr_en),
    .sts_wr_data(sts_wr_data), .sts_q(sts_q), .rx_rd_idx(rx_rd_idx),
    .rx_rd_word(rx_rd_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_idx(tx_idx), .tx_data(tx_data), .tx_last(tx_last), .flag_en(flag_en),
    .flag_clr(flag_clr), .flags(flags), .irq(irq), .sts_notify(sts_notify),
    .tx_notify(tx_notify)
  );

  function automatic logic [31:0] pack_mo(input int w);
    return {mo[4*w+3], mo[4*w+2], mo[4*w+1], mo[4*w]};
  endfunction

  function automatic logic [31:0] pack_mi(input int w);
    return {mi[4*w+3], mi[4*w+2], mi[4*w+1], mi[4*w]};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randomize_mo();
    for (int i = 0; i < 32; i++) mo[i] = 8'($urandom);
  endtask

  task automatic spi_frame(input logic [7:0] c, input logic [7:0] a, input int ndata, input int stop_bits);
    int limit;
    limit = (stop_bits > 0) ? stop_bits : 16 + 8 * ndata;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int p = 0; p < limit; p++) begin
      logic [7:0] cur;
      int bi;
      if (p < 8) cur = c;
      else if (p < 16) cur = a;
      else cur = mo[(p - 16) / 8];
      bi = 7 - (p % 8);
      spi_sclk = 1'b0;
      spi_mosi = cur[bi];
      wait_clk(HALF);
      if (p >= 16) mi[(p - 16) / 8][bi] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
    end
    spi_sclk = 1'b0;
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic check_rx(input string req);
    for (int w = 0; w < 8; w++) begin
      rx_rd_idx = 3'(w);
      wait_clk(1);
      check(req, rx_rd_word, exp_rx[w]);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 5'h1F;
    wait_clk(1);
    flag_clr = 5'h00;
    wait_clk(1);
  endtask

  task automatic local_sts(input logic [31:0] v);
    sts_wr_en = 1'b1;
    sts_wr_data = v;
    wait_clk(1);
    sts_wr_en = 1'b0;
    wait_clk(1);
  endtask

  task automatic tx_put(input int w, input logic [31:0] v, input logic last);
    tx_valid = 1'b1;
    tx_idx = 3'(w);
    tx_data = v;
    tx_last = last;
    wait_clk(1);
    tx_valid = 1'b0;
    tx_last = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] sv;
    seed_sink = $urandom(32'd1234);
    for (int w = 0; w < 8; w++) begin exp_rx[w] = '0; exp_tx[w] = '0; end
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(4);

    // R13 reset state
    check("R13 flags", 32'(flags), 32'h0);
    check("R13 irq", 32'(irq), 32'h0);
    check("R13 sts_notify", 32'(sts_notify), 32'h0);
    check("R13 tx_notify", 32'(tx_notify), 32'h0);
    check("R13 tx_ready", 32'(tx_ready), 32'h1);
    check("R13 miso", 32'(spi_miso), 32'h0);
    check("R13 sts_q", sts_q, 32'h0);
    check_rx("R13 rx words");

    flag_en = 5'h1F;
    // R1 R2 random packet writes
    for (int k = 0; k < 3; k++) begin
      randomize_mo();
      clear_flags();
      spi_frame(8'h02, 8'h00, 32, 0);
      for (int w = 0; w < 8; w++) exp_rx[w] = pack_mo(w);
      check_rx("R2 rx packing");
      check("R10 flags after buffer write", 32'(flags), 32'h09);
      check("R12 irq enabled", 32'(irq), 32'h1);
    end

    // R11 clear
    clear_flags();
    check("R11 flags cleared", 32'(flags), 32'h0);
    check("R12 irq after clear", 32'(irq), 32'h0);

    // R12 gating
    flag_en = 5'b00010;
    randomize_mo();
    spi_frame(8'h02, 8'h00, 32, 0);
    for (int w = 0; w < 8; w++) exp_rx[w] = pack_mo(w);
    check("R10 flags gated case", 32'(flags), 32'h09);
    check("R12 irq masked", 32'(irq), 32'h0);
    flag_en = 5'h1F;
    clear_flags();

    // R3 aborted write after 20 data bytes
    randomize_mo();
    spi_frame(8'h02, 8'h00, 32, 16 + 8 * 20 + 3);
    check_rx("R3 rx unchanged after abort");
    check("R3 flags after abort", 32'(flags), 32'h0);

    // R4 unknown command and bad address
    randomize_mo();
    spi_frame(8'h7E, 8'h00, 32, 0);
    check_rx("R4 rx unchanged unknown cmd");
    check("R4 flags unknown cmd", 32'(flags), 32'h0);
    check("R4 status unchanged", sts_q, 32'h0);
    spi_frame(8'h02, 8'h05, 32, 0);
    check_rx("R4 rx unchanged bad addr");
    check("R4 flags bad addr", 32'(flags), 32'h0);

    // R5 R6 status reads by both commands
    for (int k = 0; k < 2; k++) begin
      sv = $urandom;
      local_sts(sv);
      check("R6 sts_notify raised", 32'(sts_notify), 32'h1);
      clear_flags();
      spi_frame((k == 0) ? 8'h04 : 8'h05, 8'h00, 5, 0);
      check("R5 status bytes", pack_mi(0), sv);
      check("R5 byte past status", 32'(mi[4]), 32'h0);
      check("R6 sts_notify dropped", 32'(sts_notify), 32'h0);
      check("R10 flags status read", 32'(flags), 32'h05);
    end

    // R7 master status write
    clear_flags();
    randomize_mo();
    spi_frame(8'h01, 8'h00, 4, 0);
    check("R7 status from master", sts_q, pack_mo(0));
    check("R7 notify unchanged", 32'(sts_notify), 32'h0);
    check("R10 flags status write", 32'(flags), 32'h03);

    // R8 transmit packet
    clear_flags();
    for (int w = 0; w < 8; w++) begin
      exp_tx[w] = $urandom;
      tx_put(w, exp_tx[w], w == 7);
      if (w == 6) check("R8 tx_notify before last", 32'(tx_notify), 32'h0);
    end
    wait_clk(1);
    check("R8 tx_notify raised", 32'(tx_notify), 32'h1);
    spi_frame(8'h03, 8'h00, 32, 0);
    for (int w = 0; w < 8; w++) check("R8 tx bytes", pack_mi(w), exp_tx[w]);
    check("R8 tx_notify dropped", 32'(tx_notify), 32'h0);
    check("R10 flags buffer read", 32'(flags), 32'h11);

    // R9 back-pressure while chip select is low
    spi_cs_n = 1'b0;
    wait_clk(8);
    check("R9 tx_ready low in frame", 32'(tx_ready), 32'h0);
    tx_put(0, ~exp_tx[0], 1'b1);
    wait_clk(1);
    spi_cs_n = 1'b1;
    wait_clk(8);
    check("R9 tx_ready restored", 32'(tx_ready), 32'h1);
    check("R9 refused last no notify", 32'(tx_notify), 32'h0);
    spi_frame(8'h03, 8'h00, 32, 0);
    check("R9 word0 not written", pack_mi(0), exp_tx[0]);
    check_rx("R1 rx intact at end");

    summary();
  end
endmodule